// File: doc/BRIEF.md
# PC-Compatible Serial Port Register Front End

This block is the register side of a PC-style serial port with no bit shifter behind it. A host reaches eight byte-wide registers through a 3-bit offset with separate read and write strobes. Bytes the host writes to the transmit holding register are queued in a TX FIFO, which a consumer drains through a valid/pop port. Bytes arriving from outside are pushed into an RX FIFO, which the host reads through the receive buffer.

The block holds the divisor latches, the line control, interrupt enable, FIFO control and scratch registers, and an overrun flag. It ranks the pending interrupt causes into one identification code. Host reads and writes have the side effects a legacy driver expects: reading the status register or the receive buffer clears overrun, and reading the identification register clears a pending transmit-empty cause. The transmitter always reports itself ready. After every host access or received byte, the block raises a one-cycle interrupt pulse if any enabled cause is pending.

Top module: `pc_uart_regif`

## Requirements
- R1: A read strobe in cycle N gives `host_rvalid` high in cycle N+1, with `host_rdata` holding the register value from cycle N. Side effects of that read show from cycle N+1 onward.
- R2: Line-control bit 7 selects the divisor latches: offset 0 maps to the low latch and offset 1 to the high latch, for both reads and writes. After reset the low latch is 12 and the high latch is 0.
- R3: A write to the interrupt-enable register (offset 1, bit 7 of line control clear) stores bits 3:0 and reads back bits 7:4 as zero. Bit 0 enables RX data, bit 1 enables transmit-empty and bit 2 enables line status.
- R4: A write to offset 2 with bit 0 clear sets the stored FIFO control to 0. With bit 0 set it stores the value ANDed with 0xC9, and bit 1 set also empties the RX FIFO.
- R5: The identification code follows a fixed priority. Overrun with line status enabled gives 0x06. Otherwise a non-empty RX FIFO with RX enabled gives 0x0C. Otherwise a pending transmit-empty cause with TX enabled gives 0x02. Otherwise the code is 0x01.
- R6: A read of offset 2 returns the code ORed with 0xC0 when stored FIFO-control bit 0 is set. When the returned code is 0x02, the read clears the pending transmit-empty cause.
- R7: A write to offset 0 (bit 7 of line control clear) queues the byte in the TX FIFO and sets the pending transmit-empty cause. The TX port presents queued bytes in write order.
- R8: A read of offset 5 returns 0x60 | overrun<<1 | (RX FIFO non-empty). The read then clears overrun.
- R9: A read of offset 0 (bit 7 of line control clear) pops the RX FIFO and clears overrun. An empty RX FIFO reads 0xFF.
- R10: A push into a full RX FIFO sets overrun and discards the oldest byte.
- R11: The modem-status register (offset 6) and the modem-control register (offset 4) read 0. Writes to offsets 4, 5 and 6 change nothing. The scratch register (offset 7) reads back what was written.
- R12: `irq_pulse` is high for exactly one cycle, the cycle after a host access or RX push, when the code after that event is not 0x01. At all other times it is low.
- R13: After reset, line control and interrupt enable read 0, identification reads 0x01, and line status reads 0x60.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 3 | Register offset |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe (not together with read) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, registered |
| host_rvalid | output | 1 | Read data valid |
| rx_push | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | TX FIFO holds a byte |
| tx_data | output | 8 | Oldest queued TX byte |
| tx_pop | input | 1 | Consume the TX byte |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
The interrupt encoder is driven with single causes, with paired causes such as overrun and RX data, or RX data and transmit-empty, and with causes whose enable is off. This separates a wrong priority order from a missing enable mask. RX traffic runs from empty to one byte past full, which exposes drop-oldest against drop-newest and shows when overrun sets and clears. Read-side effects are checked by reading the same register twice, so a clear that never happens, or happens on the wrong read, shows up in the second value.

// File: rtl/uart_regs_pkg.sv
// Package: register offsets, identification codes and masks shared by the
// serial port register front end. Assumes a 3-bit byte offset space.
package uart_regs_pkg;
    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_IER  = 3'd1;
    localparam logic [2:0] OFS_IIR  = 3'd2;
    localparam logic [2:0] OFS_LCR  = 3'd3;
    localparam logic [2:0] OFS_MCR  = 3'd4;
    localparam logic [2:0] OFS_LSR  = 3'd5;
    localparam logic [2:0] OFS_MSR  = 3'd6;
    localparam logic [2:0] OFS_SCR  = 3'd7;

    localparam logic [7:0] FCR_KEEP_MASK = 8'hC9;
    localparam logic [7:0] LSR_TX_READY  = 8'h60;

    typedef enum logic [3:0] {
        IRQ_NONE = 4'h1,
        IRQ_THRE = 4'h2,
        IRQ_LINE = 4'h6,
        IRQ_RXTO = 4'hC
    } irq_code_e;
endpackage

// File: rtl/byte_fifo.sv
// Module: synchronous FIFO with drop-oldest on overflow.
// Assumes DEPTH is a power of two. A pop on empty is ignored. Flush wins
// over push and pop in the same cycle.
module byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic             overflow
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             pop_ok, drop_old;

    assign empty    = (cnt == '0);
    assign full     = (cnt == CW'(DEPTH));
    assign pop_ok   = pop && !empty;
    assign drop_old = push && full && !pop_ok;
    assign overflow = drop_old && !flush;
    assign dout     = mem[rp];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= wp + AW'(1);
            if (pop_ok || drop_old) rp <= rp + AW'(1);
            if (push && !pop_ok && !full) cnt <= cnt + CW'(1);
            else if (pop_ok && !push)     cnt <= cnt - CW'(1);
        end
    end

    // R10
    keep_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> full);

    // R7
    grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full && !flush) |=> (cnt == $past(cnt) + CW'(1)));
endmodule

// File: rtl/irq_prio.sv
// Module: ranks the enabled interrupt causes into one identification code.
// Purely combinational; en[0] RX data, en[1] transmit-empty, en[2] line.
module irq_prio
    import uart_regs_pkg::*;
(
    input  logic      ovr,
    input  logic      rx_ready,
    input  logic      thre_pend,
    input  logic [2:0] en,
    output irq_code_e code
);
    // Fixed-priority selection, line status first.
    always_comb begin
        if (ovr && en[2])            code = IRQ_LINE;
        else if (rx_ready && en[0])  code = IRQ_RXTO;
        else if (thre_pend && en[1]) code = IRQ_THRE;
        else                         code = IRQ_NONE;
    end
endmodule

// File: rtl/pc_uart_regif.sv
// Module: register front end of a PC-style serial port. Decodes eight byte
// registers, queues TX bytes, buffers RX bytes and pulses an interrupt.
// Assumes host_rd and host_wr are never asserted together.
module pc_uart_regif
    import uart_regs_pkg::*;
#(
    parameter int RX_DEPTH = 16,
    parameter int TX_DEPTH = 16,
    parameter int REF_HZ   = 1843200,
    parameter int BAUD     = 9600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] host_addr,
    input  logic       host_rd,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       host_rvalid,
    input  logic       rx_push,
    input  logic [7:0] rx_data,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_pop,
    output logic       irq_pulse
);
    localparam logic [15:0] DIV_RESET = 16'(REF_HZ / BAUD / 16);

    logic [7:0] lcr, scr, fcr, dll, dlm, rd_mux, rx_dout;
    logic [3:0] ier;
    logic       ovr, thre_pend, ev_q;
    logic       rx_empty, rx_full, rx_ovf, tx_empty, tx_full, tx_ovf;
    irq_code_e  code;

    wire dlab     = lcr[7];
    wire wr_thr   = host_wr && host_addr == OFS_DATA && !dlab;
    wire rd_rbr   = host_rd && host_addr == OFS_DATA && !dlab;
    wire fcr_wr   = host_wr && host_addr == OFS_IIR;
    wire rx_flush = fcr_wr && host_wdata[0] && host_wdata[1];
    wire iir_rd   = host_rd && host_addr == OFS_IIR;
    wire lsr_rd   = host_rd && host_addr == OFS_LSR;

    byte_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push),
        .din(rx_data), .pop(rd_rbr), .dout(rx_dout), .empty(rx_empty),
        .full(rx_full), .overflow(rx_ovf));

    byte_fifo #(.WIDTH(8), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(1'b0), .push(wr_thr),
        .din(host_wdata), .pop(tx_pop), .dout(tx_data), .empty(tx_empty),
        .full(tx_full), .overflow(tx_ovf));

    assign tx_valid = !tx_empty;

    irq_prio u_prio (
        .ovr(ovr), .rx_ready(!rx_empty), .thre_pend(thre_pend),
        .en(ier[2:0]), .code(code));

    // Host writes to the stored registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcr <= '0; scr <= '0; fcr <= '0; ier <= '0;
            dll <= DIV_RESET[7:0];
            dlm <= DIV_RESET[15:8];
        end else if (host_wr) begin
            if (dlab && host_addr == OFS_DATA)     dll <= host_wdata;
            else if (dlab && host_addr == OFS_IER) dlm <= host_wdata;
            else begin
                case (host_addr)
                    OFS_IER: ier <= host_wdata[3:0];
                    OFS_IIR: fcr <= host_wdata[0] ? (host_wdata & FCR_KEEP_MASK) : 8'h00;
                    OFS_LCR: lcr <= host_wdata;
                    OFS_SCR: scr <= host_wdata;
                    default: ;
                endcase
            end
        end
    end

    // Sticky conditions: transmit-empty cause and overrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thre_pend <= 1'b0;
            ovr       <= 1'b0;
        end else begin
            if (wr_thr)                         thre_pend <= 1'b1;
            else if (iir_rd && code == IRQ_THRE) thre_pend <= 1'b0;
            if (rx_ovf)                 ovr <= 1'b1;
            else if (rd_rbr || lsr_rd)  ovr <= 1'b0;
        end
    end

    // Read data selection from the pre-access state.
    always_comb begin
        if (dlab && host_addr == OFS_DATA)     rd_mux = dll;
        else if (dlab && host_addr == OFS_IER) rd_mux = dlm;
        else begin
            case (host_addr)
                OFS_DATA: rd_mux = rx_empty ? 8'hFF : rx_dout;
                OFS_IER:  rd_mux = {4'h0, ier};
                OFS_IIR:  rd_mux = {fcr[0] ? 2'b11 : 2'b00, 2'b00, code};
                OFS_LCR:  rd_mux = lcr;
                OFS_LSR:  rd_mux = LSR_TX_READY | {6'h0, ovr, !rx_empty};
                OFS_SCR:  rd_mux = scr;
                default:  rd_mux = 8'h00;
            endcase
        end
    end

    // Registered read port and access-event tracker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
            ev_q        <= 1'b0;
        end else begin
            if (host_rd) host_rdata <= rd_mux;
            host_rvalid <= host_rd;
            ev_q        <= host_rd || host_wr || rx_push;
        end
    end

    assign irq_pulse = ev_q && (code != IRQ_NONE);

    // R1
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> host_rvalid);

    // R12
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(host_rd || host_wr || rx_push));

    // R8
    lsr_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rvalid && $past(host_addr == OFS_LSR)) |-> (host_rdata[6:5] == 2'b11));

    // R6
    thre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rvalid && $past(host_addr == OFS_IIR) && host_rdata[3:0] == 4'h2) |-> !thre_pend);

    // R5
    prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code == IRQ_THRE) |-> (!(ovr && ier[2]) && !(!rx_empty && ier[0])));
endmodule

// File: tb/tb_pc_uart_regif.sv
// Directed bench for pc_uart_regif: one task per scenario, each self-checking.
module tb_pc_uart_regif;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] host_addr = '0;
    logic       host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_rvalid;
    logic       rx_push = 1'b0;
    logic [7:0] rx_data = '0;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_pop = 1'b0;
    logic       irq_pulse;

    int n_chk = 0, n_err = 0;
    bit done = 0;
    logic [7:0] rv;
    logic       irq_seen;

    always #5 clk = ~clk;

    pc_uart_regif dut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk); host_wr = 1'b0;
        irq_seen = irq_pulse;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); host_addr = a; host_rd = 1'b1;
        @(negedge clk); host_rd = 1'b0;
        n_chk++;
        if (host_rvalid !== 1'b1) begin
            n_err++;
            $display("FAIL R1: actual rvalid %0b expected 1", host_rvalid);
        end
        d = host_rdata;
        irq_seen = irq_pulse;
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk); rx_data = d; rx_push = 1'b1;
        @(negedge clk); rx_push = 1'b0;
        irq_seen = irq_pulse;
    endtask

    task automatic pop_tx(input logic [7:0] exp);
        @(negedge clk);
        chk("R7 tx_valid", {7'b0, tx_valid}, 8'h01);
        chk("R7 tx_data", tx_data, exp);
        tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic t_reset();
        rd(3'd3, rv); chk("R13 lcr", rv, 8'h00);
        rd(3'd1, rv); chk("R13 ier", rv, 8'h00);
        rd(3'd2, rv); chk("R13 iir", rv, 8'h01);
        rd(3'd5, rv); chk("R13 lsr", rv, 8'h60);
        chk("R12 no pulse idle", {7'b0, irq_seen}, 8'h00);
        wr(3'd3, 8'h80);
        rd(3'd0, rv); chk("R2 dll reset", rv, 8'd12);
        rd(3'd1, rv); chk("R2 dlm reset", rv, 8'd0);
        wr(3'd3, 8'h00);
    endtask

    task automatic t_dlab();
        wr(3'd3, 8'h83);
        wr(3'd0, 8'h34); wr(3'd1, 8'h56);
        rd(3'd0, rv); chk("R2 dll", rv, 8'h34);
        rd(3'd1, rv); chk("R2 dlm", rv, 8'h56);
        wr(3'd3, 8'h03);
        rd(3'd3, rv); chk("R2 lcr", rv, 8'h03);
        wr(3'd1, 8'hF0);
        rd(3'd1, rv); chk("R3 ier upper", rv, 8'h00);
        wr(3'd1, 8'hFF);
        rd(3'd1, rv); chk("R3 ier mask", rv, 8'h0F);
        chk("R7 no tx from dlab write", {7'b0, tx_valid}, 8'h00);
        wr(3'd3, 8'h80);
        rd(3'd0, rv); chk("R2 dll kept", rv, 8'h34);
        wr(3'd3, 8'h00);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_misc();
        wr(3'd7, 8'hA5);
        rd(3'd7, rv); chk("R11 scratch", rv, 8'hA5);
        wr(3'd4, 8'hFF);
        rd(3'd4, rv); chk("R11 mcr", rv, 8'h00);
        wr(3'd5, 8'hFF);
        rd(3'd5, rv); chk("R11 lsr write ignored", rv, 8'h60);
        wr(3'd6, 8'hFF);
        rd(3'd6, rv); chk("R11 msr", rv, 8'h00);
    endtask

    task automatic t_tx();
        wr(3'd1, 8'h02);
        wr(3'd0, 8'h11);
        chk("R12 pulse on thre", {7'b0, irq_seen}, 8'h01);
        rd(3'd2, rv); chk("R5 thre code", rv, 8'h02);
        chk("R12 no pulse after clear", {7'b0, irq_seen}, 8'h00);
        rd(3'd2, rv); chk("R6 thre cleared", rv, 8'h01);
        pop_tx(8'h11);
        wr(3'd0, 8'h22); wr(3'd0, 8'h33);
        pop_tx(8'h22); pop_tx(8'h33);
        chk("R7 tx empty", {7'b0, tx_valid}, 8'h00);
        rd(3'd2, rv);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_fcr();
        wr(3'd2, 8'hCF);
        rd(3'd2, rv); chk("R6 fifo bits", rv, 8'hC1);
        wr(3'd2, 8'h0E);
        rd(3'd2, rv); chk("R4 fcr cleared", rv, 8'h01);
        push(8'h01); push(8'h02);
        rd(3'd5, rv); chk("R8 dr set", rv, 8'h61);
        wr(3'd2, 8'h02);
        rd(3'd5, rv); chk("R4 no flush without enable", rv, 8'h61);
        wr(3'd2, 8'h03);
        rd(3'd5, rv); chk("R4 flush", rv, 8'h60);
        wr(3'd2, 8'h00);
    endtask

    task automatic t_rx();
        wr(3'd1, 8'h01);
        push(8'hAB);
        chk("R12 pulse on push", {7'b0, irq_seen}, 8'h01);
        rd(3'd2, rv); chk("R5 rx code", rv, 8'h0C);
        rd(3'd0, rv); chk("R9 rbr", rv, 8'hAB);
        chk("R12 no pulse when empty", {7'b0, irq_seen}, 8'h00);
        rd(3'd0, rv); chk("R9 empty reads ff", rv, 8'hFF);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_overrun();
        wr(3'd1, 8'h05);
        for (int i = 0; i < 17; i++) push(8'(i));
        rd(3'd2, rv); chk("R5 line code", rv, 8'h06);
        rd(3'd5, rv); chk("R10 overrun", rv, 8'h63);
        rd(3'd5, rv); chk("R8 overrun cleared", rv, 8'h61);
        rd(3'd2, rv); chk("R5 rx after line", rv, 8'h0C);
        rd(3'd0, rv); chk("R10 oldest dropped", rv, 8'h01);
        push(8'd17); push(8'd18);
        rd(3'd0, rv); chk("R10 drop again", rv, 8'h03);
        rd(3'd5, rv); chk("R9 overrun cleared by rbr", rv, 8'h61);
        wr(3'd2, 8'h03); wr(3'd2, 8'h00);
        rd(3'd5, rv); chk("R4 flushed", rv, 8'h60);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_prio();
        wr(3'd1, 8'h07);
        wr(3'd0, 8'h77);
        push(8'h55);
        rd(3'd2, rv); chk("R5 rx over thre", rv, 8'h0C);
        rd(3'd2, rv); chk("R6 thre kept", rv, 8'h0C);
        wr(3'd2, 8'h03);
        rd(3'd2, rv); chk("R6 thre with fifo", rv, 8'hC2);
        rd(3'd2, rv); chk("R6 none with fifo", rv, 8'hC1);
        chk("R12 no pulse none", {7'b0, irq_seen}, 8'h00);
        pop_tx(8'h77);
        wr(3'd2, 8'h00);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_masked();
        push(8'h10);
        chk("R12 masked push", {7'b0, irq_seen}, 8'h00);
        wr(3'd7, 8'h00);
        chk("R12 masked write", {7'b0, irq_seen}, 8'h00);
        rd(3'd2, rv); chk("R5 masked code", rv, 8'h01);
        wr(3'd2, 8'h03); wr(3'd2, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dlab();
        t_misc();
        t_tx();
        t_fcr();
        t_rx();
        t_overrun();
        t_prio();
        t_masked();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule